// File: doc/BRIEF.md
# Eviction Clear-Mask Generator

When a block leaves a set of a private cache, the block works out which tables of a hashed sharer directory may clear this core's bit for that set. An eviction and an invalidation are handled the same way. Every table of the directory picks a bucket from the block tag with its own hash function. The bit of the departing block can be cleared in a table only when no other block still resident in the same set maps to the same bucket of that table. The cache is inclusive, so only the one affected set has to be looked at. All of its tags and valid bits are already present from the normal set read, so no extra array access is needed.

The caller presents the tags and valid bits of the whole set and the way index of the departing block, and pulses a start strobe. All ways are hashed and compared in parallel. On the next cycle a done strobe comes with a small per-table clear mask. With the default four tables the mask is four bits, which fits inside a 64-bit message that is already being sent. The mask then holds until the next start.

Top module: `evc_clear_mask`

## Requirements
- R1: While reset is held low and after it is released, `done_o` is 0 and `clear_mask_o` is all zeros until the first start.
- R2: `done_o` is 1 exactly in the cycle after a cycle in which `start_i` is 1, and 0 otherwise.
- R3: Bit t of the mask (bit 0 = table 0) is 1 only when the departing way is valid and no other valid way of the set has the same table-t bucket as the departing way.
- R4: Buckets are 6 bits. Table t, for t below the last table, takes tag bits [3t+5:3t]. The last table takes the low 6 bits of the XOR of the low tag half with the high tag half. With the default 32-bit tags, that last table is bits [5:0] XOR bits [21:16].
- R5: A way whose valid bit is 0 never prevents a clear, whatever its tag.
- R6: The departing way is not compared against itself.
- R7: If the departing way's own valid bit is 0, the mask is all zeros.
- R8: Between starts, `clear_mask_o` holds its last value even if the set inputs change.
- R9: If the departing way is the only valid way of the set, every mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle per request |
| set_tags_i | input | NUM_WAYS*TAG_W | Tags of the set; way w is in bits [w*TAG_W +: TAG_W] |
| set_valid_i | input | NUM_WAYS | Valid bit of each way |
| victim_way_i | input | $clog2(NUM_WAYS) | Way index of the departing block |
| done_o | output | 1 | Result strobe, one cycle after start |
| clear_mask_o | output | NUM_TABLES | Per-table clear permission |

## Verification
The hardest case to reach from the ports is a set where the tables disagree. In that case a resident block collides with the departing block in some tables but not in others, which tests each hash bit by bit. With random wide tags such partial collisions are very rare. The stimulus therefore uses hand-built tags with single bits placed inside and outside each slice and inside the folded half. It also runs sweeps in which the tags are masked down to a few live bits, so that partial and full collisions become frequent. Every victim index is combined with random valid patterns, including invalid ways that hold colliding tags.

// File: rtl/evc_pkg.sv
// Package: shared constants for the eviction clear-mask generator.
// Assumes every directory table uses 6-bit buckets and 3-bit slice spacing.
package evc_pkg;
    localparam int BUCKET_W   = 6;
    localparam int SLICE_STEP = 3;

    typedef logic [BUCKET_W-1:0] bucket_t;
endpackage

// File: rtl/evc_hash_unit.sv
// Module: evc_hash_unit
// Maps one tag to one bucket per directory table, using the same hashes as
// the directory. Tables below the last take a 6-bit tag slice spaced 3 bits
// apart. The last table folds the two tag halves with XOR.
// Assumes TAG_W >= 2*BUCKET_W and that the slices fit inside the tag.
module evc_hash_unit
    import evc_pkg::*;
#(
    parameter int TAG_W      = 32,
    parameter int NUM_TABLES = 4
) (
    input  logic [TAG_W-1:0]               tag_i,
    output logic [NUM_TABLES*BUCKET_W-1:0] buckets_o
);
    localparam int HALF_W = TAG_W / 2;

    // XOR fold of the two tag halves, shared by the last table
    logic [HALF_W-1:0] folded;
    assign folded = tag_i[HALF_W-1:0] ^ tag_i[2*HALF_W-1:HALF_W];

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
        if (t < NUM_TABLES - 1) begin : g_slice
            // slice hash for table t
            assign buckets_o[t*BUCKET_W +: BUCKET_W] = tag_i[SLICE_STEP*t +: BUCKET_W];
        end else begin : g_fold
            // folded hash for the last table
            assign buckets_o[t*BUCKET_W +: BUCKET_W] = folded[BUCKET_W-1:0];
        end
    end
endmodule

// File: rtl/evc_victim_select.sv
// Module: evc_victim_select
// Picks the bucket vector and the valid bit of the departing way out of the
// whole set. Purely combinational.
// Assumes the way index is below NUM_WAYS.
module evc_victim_select
    import evc_pkg::*;
#(
    parameter int NUM_WAYS   = 16,
    parameter int NUM_TABLES = 4,
    parameter int WAY_IDX_W  = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*NUM_TABLES*BUCKET_W-1:0] way_buckets_i,
    input  logic [NUM_WAYS-1:0]                     way_valid_i,
    input  logic [WAY_IDX_W-1:0]                    victim_way_i,
    output logic [NUM_TABLES*BUCKET_W-1:0]          victim_buckets_o,
    output logic                                    victim_valid_o
);
    localparam int VEC_W = NUM_TABLES * BUCKET_W;

    // mux the victim's bucket vector and valid bit out of the set
    always_comb begin
        victim_buckets_o = '0;
        victim_valid_o   = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (victim_way_i == WAY_IDX_W'(w)) begin
                victim_buckets_o = way_buckets_i[w*VEC_W +: VEC_W];
                victim_valid_o   = way_valid_i[w];
            end
        end
    end
endmodule

// File: rtl/evc_conflict_net.sv
// Module: evc_conflict_net
// Compares every other valid way with the victim, table by table, and
// allows a clear wherever no such way shares the victim's bucket.
// Assumes the victim's bucket vector and valid bit are already selected.
module evc_conflict_net
    import evc_pkg::*;
#(
    parameter int NUM_WAYS   = 16,
    parameter int NUM_TABLES = 4,
    parameter int WAY_IDX_W  = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*NUM_TABLES*BUCKET_W-1:0] way_buckets_i,
    input  logic [NUM_WAYS-1:0]                     way_valid_i,
    input  logic [WAY_IDX_W-1:0]                    victim_way_i,
    input  logic [NUM_TABLES*BUCKET_W-1:0]          victim_buckets_i,
    input  logic                                    victim_valid_i,
    output logic [NUM_TABLES-1:0]                   clear_mask_o
);
    localparam int VEC_W = NUM_TABLES * BUCKET_W;

    // hit[t][w]: way w blocks the clear in table t
    logic [NUM_TABLES-1:0][NUM_WAYS-1:0] hit;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        localparam logic [WAY_IDX_W-1:0] WAY_ID = WAY_IDX_W'(w);
        logic other_live;
        // a way counts only if it is valid and is not the victim
        assign other_live = way_valid_i[w] && (victim_way_i != WAY_ID);
        for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
            // bucket equality of way w with the victim in table t
            assign hit[t][w] = other_live &&
                (way_buckets_i[w*VEC_W + t*BUCKET_W +: BUCKET_W] ==
                 victim_buckets_i[t*BUCKET_W +: BUCKET_W]);
        end
    end

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_mask
        // clear allowed only for a valid victim with no colliding neighbour
        assign clear_mask_o[t] = victim_valid_i && !(|hit[t]);
    end
endmodule

// File: rtl/evc_clear_mask.sv
// Module: evc_clear_mask (top)
// Hashes every way of the affected set, selects the departing way and
// registers the per-table clear mask. Done follows start by one cycle.
// Assumes the set inputs are stable in the start cycle. Reset is
// synchronous and active low.
module evc_clear_mask
    import evc_pkg::*;
#(
    parameter int NUM_WAYS   = 16,
    parameter int TAG_W      = 32,
    parameter int NUM_TABLES = 4,
    parameter int WAY_IDX_W  = $clog2(NUM_WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [NUM_WAYS*TAG_W-1:0]   set_tags_i,
    input  logic [NUM_WAYS-1:0]         set_valid_i,
    input  logic [WAY_IDX_W-1:0]        victim_way_i,
    output logic                        done_o,
    output logic [NUM_TABLES-1:0]       clear_mask_o
);
    localparam int VEC_W = NUM_TABLES * BUCKET_W;

    logic [NUM_WAYS*VEC_W-1:0] way_buckets;
    logic [VEC_W-1:0]          victim_buckets;
    logic                      victim_valid;
    logic [NUM_TABLES-1:0]     mask_next;
    logic                      done_q;
    logic [NUM_TABLES-1:0]     mask_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_hash
        // one hash unit per way of the set
        evc_hash_unit #(
            .TAG_W      (TAG_W),
            .NUM_TABLES (NUM_TABLES)
        ) u_hash (
            .tag_i     (set_tags_i[w*TAG_W +: TAG_W]),
            .buckets_o (way_buckets[w*VEC_W +: VEC_W])
        );
    end

    evc_victim_select #(
        .NUM_WAYS   (NUM_WAYS),
        .NUM_TABLES (NUM_TABLES),
        .WAY_IDX_W  (WAY_IDX_W)
    ) u_sel (
        .way_buckets_i    (way_buckets),
        .way_valid_i      (set_valid_i),
        .victim_way_i     (victim_way_i),
        .victim_buckets_o (victim_buckets),
        .victim_valid_o   (victim_valid)
    );

    evc_conflict_net #(
        .NUM_WAYS   (NUM_WAYS),
        .NUM_TABLES (NUM_TABLES),
        .WAY_IDX_W  (WAY_IDX_W)
    ) u_net (
        .way_buckets_i    (way_buckets),
        .way_valid_i      (set_valid_i),
        .victim_way_i     (victim_way_i),
        .victim_buckets_i (victim_buckets),
        .victim_valid_i   (victim_valid),
        .clear_mask_o     (mask_next)
    );

    // capture the mask on start and raise done for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            mask_q <= '0;
        end else begin
            done_q <= start_i;
            if (start_i) begin
                mask_q <= mask_next;
            end
        end
    end

    assign done_o       = done_q;
    assign clear_mask_o = mask_q;
endmodule

// File: rtl/evc_clear_mask_chk.sv
// Module: evc_clear_mask_chk
// Port-level properties of the clear-mask generator, bound to the top.
module evc_clear_mask_chk #(
    parameter int NUM_WAYS   = 16,
    parameter int NUM_TABLES = 4,
    parameter int WAY_IDX_W  = $clog2(NUM_WAYS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [NUM_WAYS-1:0]   set_valid_i,
    input logic [WAY_IDX_W-1:0]  victim_way_i,
    input logic                  done_o,
    input logic [NUM_TABLES-1:0] clear_mask_o
);
    logic victim_valid;
    logic victim_alone;
    assign victim_valid = set_valid_i[victim_way_i];
    assign victim_alone = (set_valid_i == (NUM_WAYS'(1) << victim_way_i));

    p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    p_done_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    p_mask_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(clear_mask_o));

    p_invalid_victim_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !victim_valid) |=> (clear_mask_o == '0));

    p_lone_victim_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && victim_alone) |=> (&clear_mask_o));
endmodule

bind evc_clear_mask evc_clear_mask_chk #(
    .NUM_WAYS   (NUM_WAYS),
    .NUM_TABLES (NUM_TABLES),
    .WAY_IDX_W  (WAY_IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .set_valid_i  (set_valid_i),
    .victim_way_i (victim_way_i),
    .done_o       (done_o),
    .clear_mask_o (clear_mask_o)
);

// File: tb/tb_evc_clear_mask.sv
// Bench for evc_clear_mask: directed hash cases plus masked-tag sweeps over
// every victim index, with expected masks from an arithmetic model.
module tb_evc_clear_mask;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 16;
    localparam int TW   = 32;
    localparam int NT   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [WAYS*TW-1:0] set_tags_i = '0;
    logic [WAYS-1:0]   set_valid_i = '0;
    logic [3:0]        victim_way_i = '0;
    logic              done_o;
    logic [NT-1:0]     clear_mask_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] tg [WAYS];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    evc_clear_mask dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .set_tags_i   (set_tags_i),
        .set_valid_i  (set_valid_i),
        .victim_way_i (victim_way_i),
        .done_o       (done_o),
        .clear_mask_o (clear_mask_o)
    );

    function automatic int bucket_of(logic [31:0] tag, int t);
        if (t < NT - 1) return int'((tag >> (3 * t)) & 32'd63);
        return int'((tag ^ (tag >> 16)) & 32'd63);
    endfunction

    function automatic logic [NT-1:0] model(logic [WAYS-1:0] v, int vic);
        logic [NT-1:0] m = '0;
        if (!v[vic]) return '0;
        for (int t = 0; t < NT; t++) begin
            m[t] = 1'b1;
            for (int w = 0; w < WAYS; w++)
                if (w != vic && v[w] && bucket_of(tg[w], t) == bucket_of(tg[vic], t))
                    m[t] = 1'b0;
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pack_tags();
        for (int w = 0; w < WAYS; w++) set_tags_i[w*TW +: TW] = tg[w];
    endtask

    // run one request; compare against model and, if given, a fixed mask
    task automatic run(input logic [WAYS-1:0] v, input int vic,
                       input string req, input logic [NT-1:0] fixed, input bit use_fixed);
        logic [NT-1:0] exp;
        logic [NT-1:0] got;
        exp = use_fixed ? fixed : model(v, vic);
        @(negedge clk);
        pack_tags();
        set_valid_i  = v;
        victim_way_i = 4'(vic);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b1, "R2 done", int'(done_o), 1);
        check(clear_mask_o === exp, req, int'(clear_mask_o), int'(exp));
        got = clear_mask_o;
        set_tags_i  = ~set_tags_i;      // disturb inputs without start
        set_valid_i = ~set_valid_i;
        @(negedge clk);
        check(done_o === 1'b0, "R2 done low", int'(done_o), 0);
        check(clear_mask_o === got, "R8 hold", int'(clear_mask_o), int'(got));
    endtask

    function automatic logic [31:0] lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed ^ (seed >> 15);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] masks [4];
        masks[0] = 32'hFFFF_FFFF; masks[1] = 32'h0000_0FFF;
        masks[2] = 32'h0003_0249; masks[3] = 32'h0001_0003;

        repeat (3) @(negedge clk);
        check(done_o === 1'b0, "R1 done", int'(done_o), 0);
        check(clear_mask_o === '0, "R1 mask", int'(clear_mask_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0 && clear_mask_o === '0, "R1 after release", int'(clear_mask_o), 0);

        // R4 directed: victim way 2 tag 0, one other valid way with a single bit
        for (int w = 0; w < WAYS; w++) tg[w] = 32'hFFFF_FFFF;
        tg[2] = 32'h0;
        tg[5] = 32'h1 << 12; run(16'h0024, 2, "R4 bit12", 4'b0000, 1);
        tg[5] = 32'h1 << 16; run(16'h0024, 2, "R4 bit16", 4'b1000, 1);
        tg[5] = 32'h1;       run(16'h0024, 2, "R4 bit0",  4'b1001, 1);
        tg[5] = 32'h1 << 4;  run(16'h0024, 2, "R4 bit4",  4'b1011, 1);
        tg[5] = 32'h1 << 7;  run(16'h0024, 2, "R4 bit7",  4'b0110, 1);

        // R5: identical tag in an invalid way does not block
        tg[5] = 32'h0; run(16'h0004, 2, "R5 invalid twin", 4'b1111, 1);
        // R3: identical tag in a valid way blocks every table
        run(16'h0024, 2, "R3 valid twin", 4'b0000, 1);
        // R6: victim alone with its own tag still clears
        run(16'h0004, 2, "R6 self excluded", 4'b1111, 1);
        // R7: victim invalid
        run(16'hFFFB, 2, "R7 invalid victim", 4'b0000, 1);
        // R9: only the victim valid, at both end indices
        run(16'h0001, 0, "R9 lone way0", 4'b1111, 1);
        run(16'h8000, 15, "R9 lone way15", 4'b1111, 1);

        // R3 sweep over every victim with masked tags for frequent collisions
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 8; r++) begin
                for (int vic = 0; vic < WAYS; vic++) begin
                    logic [WAYS-1:0] v;
                    for (int w = 0; w < WAYS; w++) tg[w] = lcg() & masks[m];
                    v = 16'(lcg());
                    if (r < 6) v[vic] = 1'b1;
                    run(v, vic, "R3 sweep", '0, 0);
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule